// File: doc/BRIEF.md
# Shadow-Memory Store/Recall Controller

This block sits in front of a byte-wide volatile RAM that has a nonvolatile twin of the same size and shape. Host reads and writes go to the RAM alone. Whole-array transfers move the contents between the two copies. A recall fills the RAM from the nonvolatile copy. A store writes the RAM image into the nonvolatile copy. A recall runs by itself after every power-up. The host can also ask for one with a particular combination of the active-low bus controls. A store comes from a decoded software command strobe. It can also come from a fall of the supply below the auto-store threshold, once auto-store has been armed.

Two safeguards protect the nonvolatile copy. No store of either kind is allowed until the host has written the RAM at least once since power-up. Holding the output enable low blocks any store from starting. The auto-store arming is lost on every power-on reset. While a transfer runs, the block raises a busy flag and ignores host accesses and further transfer requests. It shows each word it moves on a set of transfer strobes. Both arrays are modelled as registers. The transfer durations are parameters counted in clock cycles.

Top module: `shadow_mem_ctrl`

## Requirements
- R1: After `rst` or `pwr_rst` is released, a recall starts on the first clock edge. `busy` stays high for RECALL_CYC sampled cycles, and the RAM then holds the nonvolatile contents.
- R2: With ce_n=0, we_n=0, ne_n=1 and no transfer running, each clock edge writes `din` into the RAM at `addr`.
- R3: With ce_n=0, oe_n=0, we_n=1, ne_n=1 and no transfer running, `dout_en` is 1 and `dout` shows the RAM word at `addr` in the same cycle.
- R4: `dout_en` is 0 whenever ce_n is 1, oe_n is 1, ne_n is 0, or a transfer is running.
- R5: A rising edge of the host recall condition (ce_n=0, oe_n=0, ne_n=0, we_n=1) starts a recall that lasts RECALL_CYC cycles and copies every nonvolatile word into the RAM.
- R6: A one-cycle `cmd_store` pulse, given while oe_n=1 with no transfer running and at least one RAM write since power-up, starts a store. The store lasts STORE_CYC cycles and copies every RAM word into the nonvolatile array.
- R7: Until the first RAM write after power-up, both `cmd_store` and auto-store are ignored. A completed store does not clear this written state.
- R8: While oe_n=0, neither a software store nor an auto-store starts.
- R9: While auto-store is armed and a RAM write has occurred, a rising edge of `supply_low` with oe_n=1 starts a store.
- R10: `cmd_arm` arms auto-store and `cmd_disarm` disarms it. Both `rst` and `pwr_rst` leave it disarmed.
- R11: `as_n` is 0 while `supply_low` is 1, and 1 otherwise.
- R12: While `busy` is high, host RAM writes have no effect, and recall or store requests are dropped rather than queued.
- R13: In a transfer, the strobe for the destination array (`xfer_ram_we` for a recall, `xfer_nv_we` for a store) is high in the first 2**ADDR_W busy cycles. During those cycles `xfer_addr` counts 0, 1, 2 and so on. The other strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release is treated as a power-up |
| pwr_rst | input | 1 | Power-on reset indication; high while the supply is below the reset level |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; blocks stores while low |
| we_n | input | 1 | Write enable, active low |
| ne_n | input | 1 | Nonvolatile enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Data bus drive enable (0 means high impedance) |
| supply_low | input | 1 | Supply is below the auto-store threshold |
| cmd_store | input | 1 | Decoded software store strobe |
| cmd_arm | input | 1 | Decoded auto-store arm strobe |
| cmd_disarm | input | 1 | Decoded auto-store disarm strobe |
| busy | output | 1 | A recall or store is in progress |
| as_n | output | 1 | Auto-store status, active low, open-drain style |
| xfer_ram_we | output | 1 | Recall strobe: RAM word at xfer_addr is loaded from the nonvolatile array |
| xfer_nv_we | output | 1 | Store strobe: nonvolatile word at xfer_addr is loaded from RAM |
| xfer_addr | output | ADDR_W | Word index of the current transfer step |

## Verification
The hardest cases to reach from the ports involve hidden state that shows only through whether a later transfer starts: the RAM-written flag and the auto-store arming, and how each survives a completed store and a power-on reset. The bench reaches them with ordered scenarios. It tries stores before any write, again after a store with no new write, and again after a power-on reset that follows arming. It watches `busy` on the next sampled cycle each time. Dropped requests are tested by injecting a write, a recall edge and a store strobe in the first cycles of a running store. The bench then reads the RAM back and recalls the nonvolatile image to show that none of them took effect.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        XK_IDLE   = 2'd0,
        XK_RECALL = 2'd1,
        XK_STORE  = 2'd2
    } xfer_kind_e;

    typedef struct packed {
        logic rd;   // RAM read
        logic wr;   // RAM write
        logic rcl;  // host recall request level
    } host_op_t;

    function automatic host_op_t decode_bus(input logic ce_n, input logic oe_n,
                                            input logic we_n, input logic ne_n);
        host_op_t op;
        op.rd  = !ce_n && !oe_n &&  we_n &&  ne_n;
        op.wr  = !ce_n && !we_n &&  ne_n;
        op.rcl = !ce_n && !oe_n &&  we_n && !ne_n;
        return op;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/smc_policy.sv
module smc_policy
    import smc_pkg::*;
(
    input  logic clk,
    input  logic rst_any,
    input  logic busy,
    input  logic host_wr_ok,
    input  logic rcl_cond,
    input  logic oe_n,
    input  logic supply_low,
    input  logic cmd_store,
    input  logic cmd_arm,
    input  logic cmd_disarm,
    output logic start_recall,
    output logic start_store,
    output logic written
);

    logic pu_pend_q;
    logic written_q;
    logic armed_q;
    logic rcl_q;
    logic low_q;
    logic store_ok;
    logic auto_evt;

    assign start_recall = !busy && (pu_pend_q || (rcl_cond && !rcl_q));
    assign store_ok     = written_q && oe_n && !busy && !pu_pend_q;
    assign auto_evt     = armed_q && supply_low && !low_q;
    assign start_store  = store_ok && (cmd_store || auto_evt);
    assign written      = written_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            pu_pend_q <= 1'b1;
            written_q <= 1'b0;
            armed_q   <= 1'b0;
            rcl_q     <= 1'b0;
            low_q     <= 1'b0;
        end else begin
            if (!busy) pu_pend_q <= 1'b0;
            if (host_wr_ok) written_q <= 1'b1;
            if (cmd_arm)         armed_q <= 1'b1;
            else if (cmd_disarm) armed_q <= 1'b0;
            rcl_q <= rcl_cond;
            low_q <= supply_low;
        end
    end

    // R7
    written_sticky_chk: assert property (@(posedge clk) disable iff (rst_any)
        written_q |=> written_q);

    // R10
    arm_cause_chk: assert property (@(posedge clk) disable iff (rst_any)
        $rose(armed_q) |-> $past(cmd_arm));

endmodule

// File: rtl/smc_xfer_seq.sv
module smc_xfer_seq
    import smc_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int RECALL_CYC = 500,
    parameter int STORE_CYC  = 500000
) (
    input  logic              clk,
    input  logic              rst_any,
    input  logic              start_recall,
    input  logic              start_store,
    output logic              busy,
    output logic              ram_we,
    output logic              nv_we,
    output logic [ADDR_W-1:0] xaddr
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int RC_N  = max_int(RECALL_CYC, DEPTH);
    localparam int ST_N  = max_int(STORE_CYC, DEPTH);
    localparam int CW    = $clog2(max_int(RC_N, ST_N) + 1);
    localparam logic [CW-1:0] RC_LAST = CW'(RC_N - 1);
    localparam logic [CW-1:0] ST_LAST = CW'(ST_N - 1);
    localparam logic [CW-1:0] WIN_END = CW'(DEPTH);

    xfer_kind_e    kind_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          in_win;

    assign busy   = (kind_q != XK_IDLE);
    assign last   = (kind_q == XK_RECALL) ? RC_LAST : ST_LAST;
    assign in_win = (cnt_q < WIN_END);
    assign ram_we = (kind_q == XK_RECALL) && in_win;
    assign nv_we  = (kind_q == XK_STORE) && in_win;
    assign xaddr  = cnt_q[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst_any) begin
            kind_q <= XK_IDLE;
            cnt_q  <= '0;
        end else if (kind_q == XK_IDLE) begin
            cnt_q <= '0;
            if (start_recall)     kind_q <= XK_RECALL;
            else if (start_store) kind_q <= XK_STORE;
        end else if (cnt_q == last) begin
            kind_q <= XK_IDLE;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R12
    no_start_busy_chk: assert property (@(posedge clk) disable iff (rst_any)
        busy |-> !(start_recall || start_store));

    // R5
    start_excl_chk: assert property (@(posedge clk) disable iff (rst_any)
        $onehot0({start_recall, start_store}));

endmodule

// File: rtl/smc_arrays.sv
module smc_arrays #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_any,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              x_ram_we,
    input  logic              x_nv_we,
    input  logic [ADDR_W-1:0] x_addr
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram_mem [DEPTH];
    logic [DATA_W-1:0] nv_mem  [DEPTH];

    assign host_rdata = ram_mem[host_addr];

    always_ff @(posedge clk) begin
        if (host_we)       ram_mem[host_addr] <= host_din;
        else if (x_ram_we) ram_mem[x_addr]    <= nv_mem[x_addr];
        if (x_nv_we)       nv_mem[x_addr]     <= ram_mem[x_addr];
    end

    // R12
    ram_port_excl_chk: assert property (@(posedge clk) disable iff (rst_any)
        !(host_we && x_ram_we));

endmodule

// File: rtl/shadow_mem_ctrl.sv
module shadow_mem_ctrl
    import smc_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int RECALL_CYC = 500,
    parameter int STORE_CYC  = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              ne_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    input  logic              supply_low,
    input  logic              cmd_store,
    input  logic              cmd_arm,
    input  logic              cmd_disarm,
    output logic              busy,
    output logic              as_n,
    output logic              xfer_ram_we,
    output logic              xfer_nv_we,
    output logic [ADDR_W-1:0] xfer_addr
);

    logic              rst_any;
    host_op_t          op;
    logic              host_wr_ok;
    logic              start_recall;
    logic              start_store;
    logic              written;
    logic [DATA_W-1:0] rdata;

    assign rst_any    = rst || pwr_rst;
    assign op         = decode_bus(ce_n, oe_n, we_n, ne_n);
    assign host_wr_ok = op.wr && !busy;
    assign dout_en    = op.rd && !busy;
    assign dout       = dout_en ? rdata : '0;
    assign as_n       = !supply_low;

    smc_policy u_policy (
        .clk          (clk),
        .rst_any      (rst_any),
        .busy         (busy),
        .host_wr_ok   (host_wr_ok),
        .rcl_cond     (op.rcl),
        .oe_n         (oe_n),
        .supply_low   (supply_low),
        .cmd_store    (cmd_store),
        .cmd_arm      (cmd_arm),
        .cmd_disarm   (cmd_disarm),
        .start_recall (start_recall),
        .start_store  (start_store),
        .written      (written)
    );

    smc_xfer_seq #(
        .ADDR_W     (ADDR_W),
        .RECALL_CYC (RECALL_CYC),
        .STORE_CYC  (STORE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_any      (rst_any),
        .start_recall (start_recall),
        .start_store  (start_store),
        .busy         (busy),
        .ram_we       (xfer_ram_we),
        .nv_we        (xfer_nv_we),
        .xaddr        (xfer_addr)
    );

    smc_arrays #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arrays (
        .clk        (clk),
        .rst_any    (rst_any),
        .host_we    (host_wr_ok),
        .host_addr  (addr),
        .host_din   (din),
        .host_rdata (rdata),
        .x_ram_we   (xfer_ram_we),
        .x_nv_we    (xfer_nv_we),
        .x_addr     (xfer_addr)
    );

    // R4
    bus_hiz_chk: assert property (@(posedge clk) disable iff (rst_any)
        (ce_n || oe_n || !ne_n || busy) |-> !dout_en);

    // R7
    store_needs_write_chk: assert property (@(posedge clk) disable iff (rst_any)
        xfer_nv_we |-> written);

endmodule

// File: tb/shadow_mem_ctrl_tb.sv
module shadow_mem_ctrl_tb;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int RC    = 20;
    localparam int SC    = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_rst = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ne_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en;
    logic supply_low = 1'b0;
    logic cmd_store = 1'b0, cmd_arm = 1'b0, cmd_disarm = 1'b0;
    logic busy, as_n, xfer_ram_we, xfer_nv_we;
    logic [AW-1:0] xfer_addr;

    logic [DW-1:0] ram_m [DEPTH];
    logic [DW-1:0] nv_m  [DEPTH];

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    shadow_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RECALL_CYC(RC), .STORE_CYC(SC)) u_dut (
        .clk(clk), .rst(rst), .pwr_rst(pwr_rst),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .ne_n(ne_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .supply_low(supply_low), .cmd_store(cmd_store), .cmd_arm(cmd_arm),
        .cmd_disarm(cmd_disarm), .busy(busy), .as_n(as_n),
        .xfer_ram_we(xfer_ram_we), .xfer_nv_we(xfer_nv_we), .xfer_addr(xfer_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; ne_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; ne_n = 1'b1;
        addr = AW'(a); din = d;
        tick();
        ram_m[a] = d;
        bus_idle();
    endtask

    function automatic logic [DW-1:0] pat(input int sel, input int a);
        case (sel)
            1: return DW'((a * 37 + 5) % 256);
            2: return DW'(a ^ 8'h5A);
            3: return DW'((a * 3 + 1) % 256);
            default: return DW'(255 - a * 11);
        endcase
    endfunction

    task automatic wr_all(input int sel);
        for (int a = 0; a < DEPTH; a++) wr(a, pat(sel, a));
    endtask

    task automatic rd_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; ne_n = 1'b1;
            addr = AW'(a);
            #1;
            check(dout_en === 1'b1 && dout === ram_m[a], req, "read data",
                  int'(dout), int'(ram_m[a]));
        end
        bus_idle();
    endtask

    task automatic hz(input logic c, input logic o, input logic w, input logic n);
        ce_n = c; oe_n = o; we_n = w; ne_n = n;
        #1;
        check(dout_en === 1'b0, "R4", "dout_en with bus disabled", int'(dout_en), 0);
        bus_idle();
    endtask

    // Call on the sample after the start edge; k0 cycles of busy already consumed.
    task automatic wait_xfer(input int n_exp, input bit is_store, input string req,
                             input int k0);
        int k = k0;
        bit sok = 1'b1;
        while (busy === 1'b1 && k < 1000) begin
            logic act_we, oth_we;
            act_we = is_store ? xfer_nv_we : xfer_ram_we;
            oth_we = is_store ? xfer_ram_we : xfer_nv_we;
            if (act_we !== (k < DEPTH) || oth_we !== 1'b0 ||
                (k < DEPTH && xfer_addr !== AW'(k)))
                sok = 1'b0;
            k++;
            tick();
        end
        check(k == n_exp, req, "busy cycles", k, n_exp);
        if (k0 == 0) check(sok, "R13", "transfer strobe order", int'(sok), 1);
        for (int a = 0; a < DEPTH; a++) begin
            if (is_store) nv_m[a] = ram_m[a];
            else          ram_m[a] = nv_m[a];
        end
    endtask

    task automatic host_recall();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; ne_n = 1'b0;
        #1;
        check(dout_en === 1'b0, "R4", "dout_en during recall request", int'(dout_en), 0);
        tick();
        bus_idle();
    endtask

    task automatic pulse_store();
        cmd_store = 1'b1;
        tick();
        cmd_store = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bus_idle();
        repeat (3) tick();
        // reset state
        check(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(dout_en === 1'b0, "R4", "dout_en in reset", int'(dout_en), 0);
        check(as_n === 1'b1, "R11", "as_n in reset", int'(as_n), 1);

        // power-up recall
        rst = 1'b0;
        tick();
        check(busy === 1'b1, "R1", "busy after reset release", int'(busy), 1);
        wait_xfer(RC, 1'b0, "R1", 0);

        // stores ignored before any write
        pulse_store();
        check(busy === 1'b0, "R7", "software store before write", int'(busy), 0);
        cmd_arm = 1'b1; tick(); cmd_arm = 1'b0;
        supply_low = 1'b1;
        tick();
        check(busy === 1'b0, "R7", "auto-store before write", int'(busy), 0);
        check(as_n === 1'b0, "R11", "as_n with low supply", int'(as_n), 0);
        supply_low = 1'b0;
        tick();
        check(as_n === 1'b1, "R11", "as_n with good supply", int'(as_n), 1);
        cmd_disarm = 1'b1; tick(); cmd_disarm = 1'b0;

        // write and read sweep, high impedance cases
        wr_all(1);
        rd_all("R2/R3");
        hz(1'b1, 1'b0, 1'b1, 1'b1);
        hz(1'b0, 1'b1, 1'b1, 1'b1);
        hz(1'b0, 1'b0, 1'b1, 1'b0);

        // OE low blocks software store
        ce_n = 1'b1; oe_n = 1'b0;
        pulse_store();
        check(busy === 1'b0, "R8", "store with oe_n low", int'(busy), 0);
        bus_idle();

        // software store with requests injected while busy
        pulse_store();
        check(busy === 1'b1, "R6", "store start", int'(busy), 1);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; ne_n = 1'b1; addr = AW'(3);
        #1;
        check(dout_en === 1'b0, "R4", "dout_en while busy", int'(dout_en), 0);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; ne_n = 1'b1; addr = AW'(3); din = 8'hEE;
        tick();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; ne_n = 1'b0;
        tick();
        bus_idle();
        cmd_store = 1'b1;
        tick();
        cmd_store = 1'b0;
        wait_xfer(SC, 1'b1, "R6", 3);
        tick();
        check(busy === 1'b0, "R12", "requests during busy dropped", int'(busy), 0);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; ne_n = 1'b1; addr = AW'(3);
        #1;
        check(dout === pat(1, 3), "R12", "write during busy ignored", int'(dout), int'(pat(1, 3)));
        bus_idle();

        // overwrite RAM, then host recall restores stored image
        wr_all(2);
        rd_all("R2");
        host_recall();
        check(busy === 1'b1, "R5", "recall start", int'(busy), 1);
        wait_xfer(RC, 1'b0, "R5", 0);
        rd_all("R5/R6");

        // written flag survives a completed store
        pulse_store();
        check(busy === 1'b1, "R7", "store after earlier store, no new write", int'(busy), 1);
        wait_xfer(SC, 1'b1, "R7", 0);

        // auto-store
        cmd_arm = 1'b1; tick(); cmd_arm = 1'b0;
        wr_all(3);
        supply_low = 1'b1;
        tick();
        check(busy === 1'b1, "R9", "auto-store start", int'(busy), 1);
        check(as_n === 1'b0, "R11", "as_n during auto-store", int'(as_n), 0);
        wait_xfer(SC, 1'b1, "R9", 0);
        supply_low = 1'b0;
        tick();
        wr_all(4);
        host_recall();
        wait_xfer(RC, 1'b0, "R9", 0);
        rd_all("R9");

        // OE low blocks auto-store
        ce_n = 1'b1; oe_n = 1'b0;
        supply_low = 1'b1;
        tick();
        check(busy === 1'b0, "R8", "auto-store with oe_n low", int'(busy), 0);
        supply_low = 1'b0;
        bus_idle();
        tick();

        // disarm stops auto-store
        cmd_disarm = 1'b1; tick(); cmd_disarm = 1'b0;
        supply_low = 1'b1;
        tick();
        check(busy === 1'b0, "R10", "auto-store after disarm", int'(busy), 0);
        supply_low = 1'b0;
        tick();

        // power-on reset: recall, arming lost
        cmd_arm = 1'b1; tick(); cmd_arm = 1'b0;
        wr_all(4);
        pwr_rst = 1'b1;
        tick();
        tick();
        check(busy === 1'b0, "R1", "busy during power reset", int'(busy), 0);
        pwr_rst = 1'b0;
        tick();
        check(busy === 1'b1, "R1", "recall after power reset", int'(busy), 1);
        wait_xfer(RC, 1'b0, "R1", 0);
        rd_all("R1");
        wr(0, 8'h11);
        supply_low = 1'b1;
        tick();
        check(busy === 1'b0, "R10", "arming cleared by power reset", int'(busy), 0);
        supply_low = 1'b0;
        tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule